// File: doc/BRIEF.md
# Alternating-Sign Binary-to-Decimal Converter

This block converts an unsigned binary value into decimal digits using only an adder and a small counter. It needs no divider, no subtract-and-compare loop and no shift-and-add-3 network. Each digit position has a fixed power-of-ten constant, and the sign of that constant alternates from one position to the next. In each stage the constant is added to a running accumulator, once per cycle, until the accumulator's sign flips. The number of additions gives the digit, after a correction that depends on the sign of the stage. The accumulator is never restored between stages. Each stage starts from the overshoot that the previous stage left behind, and that overshoot is what lets the next constant have the opposite sign.

A mode input selects between plain decimal conversion (nine digits) and time conversion. In time mode the input is a count of 1/60-second ticks, and the six outputs are tens of hours, hours, tens of minutes, minutes, tens of seconds and seconds. The time mode uses a mixed chain of constants built from factors of ten and six. Digits leave the block most significant first, each with a one-cycle strobe. They are also collected in a packed vector, and a done pulse marks the end of the conversion.

Top module: `altsign_dec_conv`

## Requirements
- R1: After reset, digit_valid_o and done_o are low and digits_o is all zero.
- R2: With mode_i = 0, a value from 0 to 999,999,999 is accepted on start_i and gives nine decimal digits on digit_o. The digits arrive most significant first, one digit_valid_o pulse per digit, and each digit equals (value / 10^(8-i)) mod 10 for position i = 0..8.
- R3: Digit i of an n-digit result (n = 9 or 6, i = 0 most significant) is placed at digits_o[4*(n-1-i) +: 4]. In time mode, bits 35:24 are zero. digits_o is cleared when a start is accepted and holds its final value after done_o until the next accepted start.
- R4: With mode_i = 1, a tick count T below 21,600,000 gives six digits in this order: tens of hours, hours, tens of minutes, minutes, tens of seconds, seconds. These are H = T/216000, M = (T/3600) mod 60 and S = (T/60) mod 60, each split into a tens digit and a units digit. Any leftover ticks below one second are dropped.
- R5: The block performs one addition per cycle. Stage i uses a negative constant when i is even and a positive constant when i is odd. An even stage that yields digit d takes d+1 cycles, and an odd stage takes 10-d cycles. With N the sum of these stage cycles, done_o is high for exactly one cycle, N+1 cycles after the clock edge that accepts start_i. That is the cycle after the last digit_valid_o pulse.
- R6: An input of zero gives all-zero digits in both modes.
- R7: start_i is ignored from the edge that accepts a start until the cycle in which done_o is high. A start pulse in that window, with any value_i or mode_i, leaves the digits and the timing unchanged.
- R8: Every conversion gives exactly nine digit_valid_o pulses in decimal mode and six in time mode, and every digit is at most 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when the block is idle |
| mode_i | input | 1 | 0 selects decimal mode, 1 selects tick-to-time mode |
| value_i | input | 30 | Unsigned value or tick count |
| digit_o | output | 4 | Current digit of the output stream |
| digit_valid_o | output | 1 | One-cycle strobe for each digit |
| digits_o | output | 36 | Packed result, most significant digit in the highest nibble |
| done_o | output | 1 | One-cycle pulse after the last digit |

## Verification
A wrong stage constant, sign or correction shows up at once as a wrong digit, within the same stage whose strobe reports it. An accumulator that is wrongly restored or reloaded between stages does not stay in one position: it corrupts every digit after the faulty stage. A wrong stop test changes the number of cycles in a stage, so the total time from start to done_o differs from the sum predicted by the digits. Comparing that cycle count exactly catches such faults even when the digits look plausible. A start that is not properly blocked during a conversion reloads the accumulator, and the strobe count and the digits that follow no longer match.

// File: rtl/altsign_pkg.sv
package altsign_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } conv_state_e;

  // magnitude grows from the last stage upward; time chain alternates x10/x6 above 60 ticks
  function automatic longint stage_const(input bit time_mode, input int stage, input int n_stages);
    longint mag;
    mag = time_mode ? 64'sd60 : 64'sd1;
    for (int j = 1; j < 32; j++) begin
      if (j < n_stages - stage) begin
        mag = mag * ((time_mode && (j % 2 == 0)) ? 64'sd6 : 64'sd10);
      end
    end
    return (stage % 2 == 0) ? -mag : mag;
  endfunction

endpackage

// File: rtl/altsign_const_sel.sv
module altsign_const_sel #(
  parameter int ACC_W  = 32,
  parameter int N_DEC  = 9,
  parameter int N_TIME = 6,
  parameter int SEL_W  = 4
) (
  input  logic                    time_mode_i,
  input  logic [SEL_W-1:0]        stage_i,
  output logic signed [ACC_W-1:0] const_o,
  output logic                    last_o
);
  localparam int N_SLOT = 2 ** SEL_W;

  logic signed [ACC_W-1:0] dec_tbl  [N_SLOT];
  logic signed [ACC_W-1:0] time_tbl [N_SLOT];

  for (genvar s = 0; s < N_SLOT; s++) begin : g_tbl
    if (s < N_DEC) begin : g_dec
      assign dec_tbl[s] = ACC_W'(altsign_pkg::stage_const(1'b0, s, N_DEC));
    end else begin : g_dec_pad
      assign dec_tbl[s] = '0;
    end
    if (s < N_TIME) begin : g_time
      assign time_tbl[s] = ACC_W'(altsign_pkg::stage_const(1'b1, s, N_TIME));
    end else begin : g_time_pad
      assign time_tbl[s] = '0;
    end
  end

  assign const_o = time_mode_i ? time_tbl[stage_i] : dec_tbl[stage_i];
  assign last_o  = time_mode_i ? (stage_i == SEL_W'(N_TIME - 1))
                               : (stage_i == SEL_W'(N_DEC - 1));

endmodule

// File: rtl/altsign_step.sv
module altsign_step #(
  parameter int ACC_W = 32
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic signed [ACC_W-1:0] const_i,
  output logic signed [ACC_W-1:0] sum_o,
  output logic                    stop_o
);
  assign sum_o  = acc_i + const_i;
  // negative constant: stop once sum dips below zero; positive: once it is back at or above zero
  assign stop_o = const_i[ACC_W-1] ? sum_o[ACC_W-1] : ~sum_o[ACC_W-1];

endmodule

// File: rtl/altsign_digit_fix.sv
module altsign_digit_fix #(
  parameter int CNT_W = 4,
  parameter int DIG_W = 4,
  parameter int BASE  = 10
) (
  input  logic             neg_i,
  input  logic [CNT_W-1:0] adds_i,
  output logic [DIG_W-1:0] digit_o
);
  logic [CNT_W-1:0] raw;

  assign raw     = neg_i ? (adds_i - CNT_W'(1)) : (CNT_W'(BASE) - adds_i);
  assign digit_o = DIG_W'(raw);

endmodule

// File: rtl/altsign_dec_conv.sv
module altsign_dec_conv #(
  parameter int ACC_W  = 32,
  parameter int VAL_W  = 30,
  parameter int N_DEC  = 9,
  parameter int N_TIME = 6,
  parameter int DIG_W  = 4,
  parameter int BASE   = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   mode_i,
  input  logic [VAL_W-1:0]       value_i,
  output logic [DIG_W-1:0]       digit_o,
  output logic                   digit_valid_o,
  output logic [N_DEC*DIG_W-1:0] digits_o,
  output logic                   done_o
);
  import altsign_pkg::*;

  localparam int SEL_W = $clog2(N_DEC);
  localparam int CNT_W = $clog2(BASE + 1);
  localparam int OUT_W = N_DEC * DIG_W;

  conv_state_e             state_q;
  logic                    mode_q;
  logic [SEL_W-1:0]        stage_q;
  logic signed [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [OUT_W-1:0]        digits_q;
  logic [DIG_W-1:0]        digit_q;
  logic                    valid_q;
  logic                    done_q;

  logic signed [ACC_W-1:0] stage_const;
  logic signed [ACC_W-1:0] sum;
  logic                    last_stage;
  logic                    stop;
  logic [CNT_W-1:0]        adds;
  logic [DIG_W-1:0]        fixed_digit;
  logic [SEL_W-1:0]        last_idx;
  logic [SEL_W-1:0]        slot;

  altsign_const_sel #(
    .ACC_W (ACC_W),
    .N_DEC (N_DEC),
    .N_TIME(N_TIME),
    .SEL_W (SEL_W)
  ) u_const_sel (
    .time_mode_i(mode_q),
    .stage_i    (stage_q),
    .const_o    (stage_const),
    .last_o     (last_stage)
  );

  altsign_step #(
    .ACC_W(ACC_W)
  ) u_step (
    .acc_i  (acc_q),
    .const_i(stage_const),
    .sum_o  (sum),
    .stop_o (stop)
  );

  assign adds = cnt_q + CNT_W'(1);

  altsign_digit_fix #(
    .CNT_W(CNT_W),
    .DIG_W(DIG_W),
    .BASE (BASE)
  ) u_digit_fix (
    .neg_i  (stage_const[ACC_W-1]),
    .adds_i (adds),
    .digit_o(fixed_digit)
  );

  assign last_idx = mode_q ? SEL_W'(N_TIME - 1) : SEL_W'(N_DEC - 1);
  assign slot     = last_idx - stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      stage_q  <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      digits_q <= '0;
      digit_q  <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q   <= mode_i;
            acc_q    <= {{(ACC_W - VAL_W){1'b0}}, value_i};
            stage_q  <= '0;
            cnt_q    <= '0;
            digits_q <= '0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc_q <= sum;
          if (stop) begin
            digit_q <= fixed_digit;
            valid_q <= 1'b1;
            for (int i = 0; i < N_DEC; i++) begin
              if (SEL_W'(i) == slot) digits_q[i*DIG_W +: DIG_W] <= fixed_digit;
            end
            cnt_q <= '0;
            if (last_stage) state_q <= ST_DONE;
            else            stage_q <= stage_q + SEL_W'(1);
          end else begin
            cnt_q <= adds;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign digit_o       = digit_q;
  assign digit_valid_o = valid_q;
  assign digits_o      = digits_q;
  assign done_o        = done_q;

  // a stage never needs more than BASE additions for in-range inputs
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q < CNT_W'(BASE)));

  // carried overshoot: negative stages start non-negative, positive stages start negative
  assert_carry_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q == '0) |-> (acc_q[ACC_W-1] == ~stage_const[ACC_W-1]));

  assert_digit_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_valid_o |-> (digit_o <= DIG_W'(BASE - 1)));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(digit_valid_o));

  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(mode_q));

endmodule

// File: tb/altsign_dec_conv_tb.sv
module altsign_dec_conv_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [29:0] value_i = '0;
  logic [3:0]  digit_o;
  logic        digit_valid_o;
  logic [35:0] digits_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  altsign_dec_conv u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .value_i      (value_i),
    .digit_o      (digit_o),
    .digit_valid_o(digit_valid_o),
    .digits_o     (digits_o),
    .done_o       (done_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input bit m, input longint v, input bit poke);
    int     exp_d[9];
    int     got[9];
    int     n;
    int     ng;
    int     cycles;
    int     exp_cyc;
    longint exp_pack;
    longint hrs;
    longint mins;
    longint secs;
    longint p;
    bit     seen_done;
    n = m ? 6 : 9;
    if (!m) begin
      p = 100000000;
      for (int i = 0; i < 9; i++) begin
        exp_d[i] = int'((v / p) % 10);
        p = p / 10;
      end
    end else begin
      hrs  = v / 216000;
      mins = (v / 3600) % 60;
      secs = (v / 60) % 60;
      exp_d[0] = int'(hrs / 10);
      exp_d[1] = int'(hrs % 10);
      exp_d[2] = int'(mins / 10);
      exp_d[3] = int'(mins % 10);
      exp_d[4] = int'(secs / 10);
      exp_d[5] = int'(secs % 10);
    end
    exp_pack = 0;
    exp_cyc  = 1;
    for (int i = 0; i < n; i++) begin
      exp_pack = exp_pack * 16 + longint'(exp_d[i]);
      exp_cyc  = exp_cyc + ((i % 2 == 0) ? exp_d[i] + 1 : 10 - exp_d[i]);
    end
    for (int i = 0; i < 9; i++) got[i] = 0;

    @(negedge clk);
    start_i = 1'b1;
    mode_i  = m;
    value_i = v[29:0];
    @(negedge clk);
    start_i = 1'b0;
    cycles = 0;
    ng = 0;
    seen_done = 1'b0;
    while (!seen_done && cycles < 200) begin
      @(negedge clk);
      cycles++;
      if (poke && cycles == 3) begin
        start_i = 1'b1;
        mode_i  = ~m;
        value_i = 30'd12345678;
      end
      if (poke && cycles == 4) start_i = 1'b0;
      if (digit_valid_o) begin
        if (ng < 9) got[ng] = int'(digit_o);
        ng++;
      end
      if (done_o) seen_done = 1'b1;
    end
    start_i = 1'b0;

    chk(seen_done, "R5 done_o seen", longint'(seen_done), 1);
    chk(ng == n, "R8 strobe count", ng, n);
    for (int i = 0; i < n; i++) begin
      chk(got[i] == exp_d[i], m ? "R4 time digit" : "R2 decimal digit", got[i], exp_d[i]);
    end
    chk(longint'(digits_o) == exp_pack, "R3 packed digits", longint'(digits_o), exp_pack);
    chk(cycles == exp_cyc, "R5 start-to-done cycles", cycles, exp_cyc);
    if (poke) begin
      chk(longint'(digits_o) == exp_pack, "R7 start while busy ignored", longint'(digits_o), exp_pack);
    end
    if (v == 0) begin
      chk(digits_o == '0, "R6 zero input", longint'(digits_o), 0);
    end
    @(negedge clk);
    chk(!done_o, "R5 done single cycle", longint'(done_o), 0);
    chk(longint'(digits_o) == exp_pack, "R3 result held", longint'(digits_o), exp_pack);
  endtask

  initial begin
    longint dec_list[10];
    longint time_list[10];
    dec_list  = '{0, 1, 9, 10, 99999999, 100000000, 999999999, 123456789, 987654321, 500000000};
    time_list = '{0, 59, 60, 3599, 3600, 215999, 216000, 2159999, 2160000, 21599999};

    repeat (3) @(negedge clk);
    chk(digits_o == '0, "R1 reset digits", longint'(digits_o), 0);
    chk(!digit_valid_o, "R1 reset valid", longint'(digit_valid_o), 0);
    chk(!done_o, "R1 reset done", longint'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(digits_o == '0 && !done_o && !digit_valid_o, "R1 idle after reset", longint'(digits_o), 0);

    for (int i = 0; i < 10; i++) run(1'b0, dec_list[i], i[0]);
    for (int i = 0; i < 10; i++) run(1'b1, time_list[i], i[0]);
    for (int i = 0; i < 64; i++) run(1'b0, longint'(i), 1'b0);
    for (int i = 0; i < 150; i++) begin
      run(1'b0, (longint'(i) * 7368787 + longint'(i) * longint'(i) * 1299709) % 1000000000, (i % 4) == 0);
      run(1'b1, (longint'(i) * 1234577 + longint'(i) * longint'(i) * 7919) % 21600000, (i % 4) == 2);
    end
    for (int i = 0; i < 120; i++) run(1'b1, longint'(i) * 61, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule